// File: doc/BRIEF.md
# Serial Bus Master Register Interface

This block is the software-facing front of a two-wire serial bus master. A 32-bit register bus with a single write strobe and a combinational read path reaches a small set of configuration, command and status registers. Software programs a command code, a register address, write data and a device/runtime address, then sets a launch bit. The block pulses a start strobe to the wire engine, reads busy until the engine reports the end, latches completion, error and rejected-write status, and drives one interrupt line.

Besides ordinary transfers it offers an abort that stops a running transfer, a soft reset that returns every register to its reset value, a self-clearing request that starts the bus-wide device-mode initialisation sequence, and direct software control of the two bus lines with readback of their live levels. The wire engine is not part of this block. It sees only plain single-cycle strobes and level outputs. There is no valid/ready stream at either edge: the register bus is never stalled, and a write that cannot be taken is dropped and flagged.

Top module: `sbc_regif`

## Requirements
- R1: After reset, CTRL (0x00), INTE (0x08), INTS (0x0C), ADDR (0x10), DATA (0x1C), LCR (0x24, bits 3:0), CMD (0x2C), DAR (0x30) and CCR (0x04) read 0, DMCR (0x28) reads 0x007C3E00, and irq is low.
- R2: Writing CTRL with bit 7 set and bits 6 and 0 clear, while no transfer or init is running, sets busy (CTRL bit 7 reads 1). eng_start is high for exactly the one cycle after the write. Busy stays set until the cycle after eng_done.
- R3: A transfer ends when eng_done is seen while busy. This sets INTS bit 0, also sets INTS bit 1 if eng_err is high, and loads eng_ack_err into INTS bit 16 and eng_err_pos into INTS bits 11:8.
- R4: When a transfer ends with CMD 0x8B, 0x9C or 0xA6, DATA is loaded with the low 8, 16 or 32 bits of eng_rdata, zero-extended. Any other command leaves DATA unchanged.
- R5: While busy, writes to ADDR, DATA, CMD or DAR are ignored and set INTS bit 2 (load busy).
- R6: Writing 1 to INTS bits 2:0 clears those flags and writing 0 leaves them. A flag being set in the same cycle wins over the clear.
- R7: irq is high exactly when CTRL bit 1 (global enable) is set and, for some i in 0..2, both INTS bit i and INTE bit i are set.
- R8: Writing CTRL with bit 6 set while busy clears busy, sets INTS bit 1 and pulses eng_abort for one cycle. An eng_done in that same cycle or later is ignored. Bit 6 has no effect while idle.
- R9: Writing CTRL with bit 0 set makes CTRL bit 0 read 1 for one cycle. After that, every register is back at its R1 value.
- R10: Writing DMCR with bit 31 set while idle pulses init_start for one cycle and makes DMCR bit 31 read 1 until init_done. DMCR bits 23:0 are read/write and drive init_word. While init runs, a CTRL launch is ignored.
- R11: LCR bits 3:0 drive sda_ovr_en (bit 0), sda_ovr_lvl (bit 1), scl_ovr_en (bit 2) and scl_ovr_lvl (bit 3). LCR bits 4 and 5 read the live sda_in and scl_in.
- R12: CCR bits 7:0 drive clk_div and bits 10:8 drive sda_delay. DAR bits 15:0 drive eng_hw_addr and bits 23:16 drive eng_rt_addr. ADDR bits 7:0, CMD and DATA drive eng_reg_addr, eng_cmd and eng_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle transfer launch strobe |
| eng_abort | output | 1 | One-cycle abort strobe |
| eng_cmd | output | 8 | Command code |
| eng_reg_addr | output | 8 | Target register address |
| eng_wdata | output | 32 | Write data for the transfer |
| eng_hw_addr | output | 16 | Device hardware address |
| eng_rt_addr | output | 8 | Runtime address |
| eng_done | input | 1 | Transfer end strobe from engine |
| eng_err | input | 1 | Transfer failed (valid with eng_done) |
| eng_ack_err | input | 1 | Acknowledge error (valid with eng_done) |
| eng_err_pos | input | 4 | Failing data position (valid with eng_done) |
| eng_rdata | input | 32 | Read data (valid with eng_done) |
| init_start | output | 1 | One-cycle init sequence strobe |
| init_word | output | 24 | Mode data, mode register and device address for init |
| init_done | input | 1 | Init sequence end strobe |
| clk_div | output | 8 | Bus clock divider |
| sda_delay | output | 3 | Data output delay |
| sda_ovr_en | output | 1 | Software drives data line |
| sda_ovr_lvl | output | 1 | Data line level when overridden |
| scl_ovr_en | output | 1 | Software drives clock line |
| scl_ovr_lvl | output | 1 | Clock line level when overridden |
| sda_in | input | 1 | Live data line level |
| scl_in | input | 1 | Live clock line level |

## Verification
The bench goes after the edges of the busy window. A design that checked busy one cycle late would accept a write to DATA or CMD just after launch, and would then miss the load-busy flag. An end strobe that arrives after an abort must be dropped. A design that still honoured it would set the transfer-over flag and overwrite DATA. Each read width is checked for masking, because a wrong mask leaks upper bytes of the returned word. The bench also launches a transfer while init is still pending, and checks that the soft reset reads as set for exactly one cycle before all registers return to their reset values, DMCR's non-zero default included.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned N_SRC  = 3;

  localparam logic [BUS_AW-1:0] OFF_CTRL = 8'h00;
  localparam logic [BUS_AW-1:0] OFF_CCR  = 8'h04;
  localparam logic [BUS_AW-1:0] OFF_INTE = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_INTS = 8'h0C;
  localparam logic [BUS_AW-1:0] OFF_ADDR = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_DATA = 8'h1C;
  localparam logic [BUS_AW-1:0] OFF_LCR  = 8'h24;
  localparam logic [BUS_AW-1:0] OFF_DMCR = 8'h28;
  localparam logic [BUS_AW-1:0] OFF_CMD  = 8'h2C;
  localparam logic [BUS_AW-1:0] OFF_DAR  = 8'h30;

  localparam logic [7:0] CMD_RD_B = 8'h8B;
  localparam logic [7:0] CMD_RD_H = 8'h9C;
  localparam logic [7:0] CMD_RD_W = 8'hA6;

  localparam logic [23:0] INIT_WORD_RST = 24'h7C3E00;

  // Mask of valid read bits for a command; zero for non-read commands.
  function automatic logic [BUS_DW-1:0] read_mask(input logic [7:0] code);
    case (code)
      CMD_RD_B: read_mask = 32'h0000_00FF;
      CMD_RD_H: read_mask = 32'h0000_FFFF;
      CMD_RD_W: read_mask = 32'hFFFF_FFFF;
      default:  read_mask = 32'h0;
    endcase
  endfunction

  function automatic logic is_read(input logic [7:0] code);
    is_read = (code == CMD_RD_B) || (code == CMD_RD_H) || (code == CMD_RD_W);
  endfunction
endpackage

// File: rtl/sbc_xfer_ctl.sv
module sbc_xfer_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wd_srst,
  input  logic wd_gie,
  input  logic wd_abort,
  input  logic wd_start,
  input  logic wr_dmcr,
  input  logic wd_init,
  input  logic eng_done,
  input  logic init_done,
  output logic busy,
  output logic gie,
  output logic srst,
  output logic init_busy,
  output logic eng_start,
  output logic eng_abort,
  output logic init_start,
  output logic xfer_end,
  output logic abort_evt
);
  logic do_srst, do_abort, do_start, do_init;

  // Priority inside one CTRL write: soft reset, then abort, then launch.
  assign do_srst  = wr_ctrl & wd_srst;
  assign do_abort = wr_ctrl & ~wd_srst & wd_abort & busy;
  assign do_start = wr_ctrl & ~wd_srst & ~wd_abort & wd_start & ~busy & ~init_busy;
  assign do_init  = wr_dmcr & wd_init & ~busy & ~init_busy;
  assign xfer_end  = busy & eng_done & ~do_abort;
  assign abort_evt = do_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; gie <= 1'b0; srst <= 1'b0; init_busy <= 1'b0;
      eng_start <= 1'b0; eng_abort <= 1'b0; init_start <= 1'b0;
    end else if (srst) begin
      busy <= 1'b0; gie <= 1'b0; srst <= 1'b0; init_busy <= 1'b0;
      eng_start <= 1'b0; eng_abort <= 1'b0; init_start <= 1'b0;
    end else begin
      srst       <= do_srst;
      eng_start  <= do_start;
      eng_abort  <= do_abort;
      init_start <= do_init;
      if (wr_ctrl && !wd_srst) gie <= wd_gie;
      if (do_start)                 busy <= 1'b1;
      else if (do_abort || xfer_end) busy <= 1'b0;
      if (do_init)        init_busy <= 1'b1;
      else if (init_done) init_busy <= 1'b0;
    end
  end

  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy); // R2
  AST_ABORT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> (!busy && !eng_start)); // R8
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !srst); // R9
  AST_INIT_HELD: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (init_busy && !init_done) |=> init_busy); // R10
endmodule

// File: rtl/sbc_int_stat.sv
module sbc_int_stat #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned POSW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [NSRC-1:0] w1c_mask,
  input  logic            wr_en_reg,
  input  logic [NSRC-1:0] en_wdata,
  input  logic [NSRC-1:0] set_vec,
  input  logic            load_detail,
  input  logic            ack_err_in,
  input  logic [POSW-1:0] err_pos_in,
  input  logic            gie,
  output logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] enables,
  output logic            ack_err,
  output logic [POSW-1:0] err_pos,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (clr)        flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (w1c_mask[i]) flags[i] <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n || clr)
      set_vec[i] |=> flags[i]); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (w1c_mask[i] && !set_vec[i]) |=> !flags[i]); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enables <= '0; ack_err <= 1'b0; err_pos <= '0;
    end else if (clr) begin
      enables <= '0; ack_err <= 1'b0; err_pos <= '0;
    end else begin
      if (wr_en_reg) enables <= en_wdata;
      if (load_detail) begin
        ack_err <= ack_err_in;
        err_pos <= err_pos_in;
      end
    end
  end

  assign irq = gie & |(flags & enables);

  AST_DETAIL_LOADED: assert property (@(posedge clk) disable iff (!rst_n || clr)
    load_detail |=> (ack_err == $past(ack_err_in))); // R3
endmodule

// File: rtl/sbc_regif.sv
module sbc_regif
  import sbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        eng_start,
  output logic        eng_abort,
  output logic [7:0]  eng_cmd,
  output logic [7:0]  eng_reg_addr,
  output logic [31:0] eng_wdata,
  output logic [15:0] eng_hw_addr,
  output logic [7:0]  eng_rt_addr,
  input  logic        eng_done,
  input  logic        eng_err,
  input  logic        eng_ack_err,
  input  logic [3:0]  eng_err_pos,
  input  logic [31:0] eng_rdata,
  output logic        init_start,
  output logic [23:0] init_word,
  input  logic        init_done,
  output logic [7:0]  clk_div,
  output logic [2:0]  sda_delay,
  output logic        sda_ovr_en,
  output logic        sda_ovr_lvl,
  output logic        scl_ovr_en,
  output logic        scl_ovr_lvl,
  input  logic        sda_in,
  input  logic        scl_in
);
  localparam int unsigned POSW = 4;

  logic busy, gie, srst, init_busy, xfer_end, abort_evt;
  logic wr_ok;
  logic hit_ctrl, hit_ccr, hit_inte, hit_ints, hit_addr, hit_data;
  logic hit_lcr, hit_dmcr, hit_cmd, hit_dar, blocked;
  logic [10:0] ccr_q;
  logic [7:0]  addr_q, cmd_q;
  logic [31:0] data_q;
  logic [3:0]  lcr_q;
  logic [23:0] dmcr_q, dar_q;
  logic [N_SRC-1:0] flags, enables, set_vec;
  logic        ack_err;
  logic [POSW-1:0] err_pos;

  assign wr_ok    = bus_wr & ~srst;
  assign hit_ctrl = wr_ok && (bus_addr == OFF_CTRL);
  assign hit_ccr  = wr_ok && (bus_addr == OFF_CCR);
  assign hit_inte = wr_ok && (bus_addr == OFF_INTE);
  assign hit_ints = wr_ok && (bus_addr == OFF_INTS);
  assign hit_addr = wr_ok && (bus_addr == OFF_ADDR);
  assign hit_data = wr_ok && (bus_addr == OFF_DATA);
  assign hit_lcr  = wr_ok && (bus_addr == OFF_LCR);
  assign hit_dmcr = wr_ok && (bus_addr == OFF_DMCR);
  assign hit_cmd  = wr_ok && (bus_addr == OFF_CMD);
  assign hit_dar  = wr_ok && (bus_addr == OFF_DAR);
  assign blocked  = busy & (hit_addr | hit_data | hit_cmd | hit_dar);

  sbc_xfer_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(hit_ctrl), .wd_srst(bus_wdata[0]), .wd_gie(bus_wdata[1]),
    .wd_abort(bus_wdata[6]), .wd_start(bus_wdata[7]),
    .wr_dmcr(hit_dmcr), .wd_init(bus_wdata[31]),
    .eng_done(eng_done), .init_done(init_done),
    .busy(busy), .gie(gie), .srst(srst), .init_busy(init_busy),
    .eng_start(eng_start), .eng_abort(eng_abort), .init_start(init_start),
    .xfer_end(xfer_end), .abort_evt(abort_evt)
  );

  // Source order: 0 transfer over, 1 transfer error, 2 load busy.
  assign set_vec = {blocked, (xfer_end & eng_err) | abort_evt, xfer_end};

  sbc_int_stat #(.NSRC(N_SRC), .POSW(POSW)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(srst),
    .w1c_mask(hit_ints ? bus_wdata[N_SRC-1:0] : '0),
    .wr_en_reg(hit_inte), .en_wdata(bus_wdata[N_SRC-1:0]),
    .set_vec(set_vec), .load_detail(xfer_end),
    .ack_err_in(eng_ack_err), .err_pos_in(eng_err_pos),
    .gie(gie), .flags(flags), .enables(enables),
    .ack_err(ack_err), .err_pos(err_pos), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= '0; addr_q <= '0; cmd_q <= '0; data_q <= '0;
      lcr_q <= '0; dmcr_q <= INIT_WORD_RST; dar_q <= '0;
    end else if (srst) begin
      ccr_q <= '0; addr_q <= '0; cmd_q <= '0; data_q <= '0;
      lcr_q <= '0; dmcr_q <= INIT_WORD_RST; dar_q <= '0;
    end else begin
      if (hit_ccr)  ccr_q  <= bus_wdata[10:0];
      if (hit_lcr)  lcr_q  <= bus_wdata[3:0];
      if (hit_dmcr) dmcr_q <= bus_wdata[23:0];
      if (!busy) begin
        if (hit_addr) addr_q <= bus_wdata[7:0];
        if (hit_cmd)  cmd_q  <= bus_wdata[7:0];
        if (hit_dar)  dar_q  <= bus_wdata[23:0];
        if (hit_data) data_q <= bus_wdata;
      end
      if (xfer_end && is_read(cmd_q)) data_q <= eng_rdata & read_mask(cmd_q);
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = {24'h0, busy, 5'h0, gie, srst};
      OFF_CCR:  bus_rdata = {21'h0, ccr_q};
      OFF_INTE: bus_rdata = {{(32-N_SRC){1'b0}}, enables};
      OFF_INTS: bus_rdata = {15'h0, ack_err, 4'h0, err_pos, 5'h0, flags};
      OFF_ADDR: bus_rdata = {24'h0, addr_q};
      OFF_DATA: bus_rdata = data_q;
      OFF_LCR:  bus_rdata = {26'h0, scl_in, sda_in, lcr_q};
      OFF_DMCR: bus_rdata = {init_busy, 7'h0, dmcr_q};
      OFF_CMD:  bus_rdata = {24'h0, cmd_q};
      OFF_DAR:  bus_rdata = {8'h0, dar_q};
      default:  bus_rdata = 32'h0;
    endcase
  end

  assign eng_cmd      = cmd_q;
  assign eng_reg_addr = addr_q;
  assign eng_wdata    = data_q;
  assign eng_hw_addr  = dar_q[15:0];
  assign eng_rt_addr  = dar_q[23:16];
  assign init_word    = dmcr_q;
  assign clk_div      = ccr_q[7:0];
  assign sda_delay    = ccr_q[10:8];
  assign sda_ovr_en   = lcr_q[0];
  assign sda_ovr_lvl  = lcr_q[1];
  assign scl_ovr_en   = lcr_q[2];
  assign scl_ovr_lvl  = lcr_q[3];

  AST_BLOCKED_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (busy && hit_cmd) |=> $stable(eng_cmd)); // R5
  AST_BLOCKED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n || srst)
    blocked |=> flags[2]); // R5
endmodule

// File: tb/sbc_regif_tb.sv
module sbc_regif_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0; logic [7:0] bus_addr = 0; logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq, eng_start, eng_abort, init_start;
  logic [7:0] eng_cmd, eng_reg_addr, eng_rt_addr, clk_div;
  logic [31:0] eng_wdata; logic [15:0] eng_hw_addr; logic [23:0] init_word;
  logic [2:0] sda_delay;
  logic sda_ovr_en, sda_ovr_lvl, scl_ovr_en, scl_ovr_lvl;
  logic eng_done = 0, eng_err = 0, eng_ack_err = 0, init_done = 0;
  logic [3:0] eng_err_pos = 0; logic [31:0] eng_rdata = 0;
  logic sda_in = 0, scl_in = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbc_regif u_dut (.*);

  // Behavioural reference model
  bit m_busy, m_gie, m_srst, m_init, m_start, m_abort, m_istart;
  bit [2:0] m_flags, m_en; bit m_ack; bit [3:0] m_pos;
  bit [10:0] m_ccr; bit [7:0] m_addr, m_cmd; bit [31:0] m_data;
  bit [3:0] m_lcr; bit [23:0] m_dmcr, m_dar;

  task automatic model_reset();
    m_busy = 0; m_gie = 0; m_srst = 0; m_init = 0;
    m_start = 0; m_abort = 0; m_istart = 0;
    m_flags = 0; m_en = 0; m_ack = 0; m_pos = 0;
    m_ccr = 0; m_addr = 0; m_cmd = 0; m_data = 0; m_lcr = 0;
    m_dmcr = 24'h7C3E00; m_dar = 0;
  endtask

  function automatic bit [31:0] width_bits(bit [7:0] c);
    if (c == 8'h8B) return 32'hFF;
    if (c == 8'h9C) return 32'hFFFF;
    if (c == 8'hA6) return 32'hFFFF_FFFF;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    bit wc, ab, st, fin, ini, lb, isrd;
    if (!rst_n || m_srst) model_reset();
    else begin
      wc  = bus_wr && bus_addr == 8'h00;
      ab  = wc && !bus_wdata[0] && bus_wdata[6] && m_busy;
      st  = wc && !bus_wdata[0] && !bus_wdata[6] && bus_wdata[7] && !m_busy && !m_init;
      fin = m_busy && eng_done && !ab;
      ini = bus_wr && bus_addr == 8'h28 && bus_wdata[31] && !m_busy && !m_init;
      lb  = m_busy && bus_wr && (bus_addr == 8'h10 || bus_addr == 8'h1C ||
                                 bus_addr == 8'h2C || bus_addr == 8'h30);
      isrd = width_bits(m_cmd) != 0;
      if (bus_wr && bus_addr == 8'h0C) m_flags = m_flags & ~bus_wdata[2:0];
      if (fin) m_flags[0] = 1;
      if ((fin && eng_err) || ab) m_flags[1] = 1;
      if (lb) m_flags[2] = 1;
      if (fin) begin
        m_ack = eng_ack_err; m_pos = eng_err_pos;
        if (isrd) m_data = eng_rdata & width_bits(m_cmd);
      end
      if (bus_wr && !m_busy) begin
        if (bus_addr == 8'h10) m_addr = bus_wdata[7:0];
        if (bus_addr == 8'h2C) m_cmd = bus_wdata[7:0];
        if (bus_addr == 8'h30) m_dar = bus_wdata[23:0];
        if (bus_addr == 8'h1C) m_data = bus_wdata;
      end
      if (bus_wr && bus_addr == 8'h04) m_ccr = bus_wdata[10:0];
      if (bus_wr && bus_addr == 8'h24) m_lcr = bus_wdata[3:0];
      if (bus_wr && bus_addr == 8'h28) m_dmcr = bus_wdata[23:0];
      if (bus_wr && bus_addr == 8'h08) m_en = bus_wdata[2:0];
      if (wc && !bus_wdata[0]) m_gie = bus_wdata[1];
      m_srst = wc && bus_wdata[0];
      m_start = st; m_abort = ab; m_istart = ini;
      if (st) m_busy = 1; else if (ab || fin) m_busy = 0;
      if (ini) m_init = 1; else if (init_done) m_init = 0;
    end
  end

  function automatic bit [31:0] mread(bit [7:0] a);
    case (a)
      8'h00: return {24'h0, m_busy, 5'h0, m_gie, m_srst};
      8'h04: return {21'h0, m_ccr};
      8'h08: return {29'h0, m_en};
      8'h0C: return {15'h0, m_ack, 4'h0, m_pos, 5'h0, m_flags};
      8'h10: return {24'h0, m_addr};
      8'h1C: return m_data;
      8'h24: return {26'h0, scl_in, sda_in, m_lcr};
      8'h28: return {m_init, 7'h0, m_dmcr};
      8'h2C: return {24'h0, m_cmd};
      8'h30: return {8'h0, m_dar};
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit [31:0] act, bit [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({29'h0, eng_start, eng_abort, init_start}, {29'h0, m_start, m_abort, m_istart},
          "R2/R8/R10 strobes");
      chk({31'h0, irq}, {31'h0, m_gie && |(m_flags & m_en)}, "R7 irq");
      chk({clk_div, sda_delay, eng_rt_addr, eng_hw_addr},
          {m_ccr[7:0], m_ccr[10:8], m_dar[23:16], m_dar[15:0]}, "R12 config");
      chk({eng_cmd, eng_reg_addr, init_word}, {m_cmd, m_addr, m_dmcr}, "R12/R10 mirrors");
      chk(eng_wdata, m_data, "R12 data");
      chk({28'h0, scl_ovr_lvl, scl_ovr_en, sda_ovr_lvl, sda_ovr_en}, {28'h0, m_lcr},
          "R11 overrides");
    end
  end

  task automatic wr(bit [7:0] a, bit [31:0] d);
    @(negedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd_now(bit [7:0] a, string tag);
    bus_addr = a; #1 chk(bus_rdata, mread(a), tag);
  endtask

  task automatic rd(bit [7:0] a, string tag);
    @(negedge clk); #1 rd_now(a, tag);
  endtask

  task automatic finish_xfer(bit e, bit ak, bit [3:0] p, bit [31:0] rdv);
    @(negedge clk); #1 eng_done = 1; eng_err = e; eng_ack_err = ak; eng_err_pos = p;
    eng_rdata = rdv;
    @(negedge clk); #1 eng_done = 0; eng_err = 0; eng_ack_err = 0; eng_err_pos = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual %0d expected <= 20000", cyc);
      summary();
    end
  end

  initial begin
    idle(3); #1 rst_n = 1;
    // R1 reset values
    foreach (u_rst_list[i]) rd(u_rst_list[i], "R1 reset read");
    rd(8'h28, "R1 dmcr"); chk(bus_rdata, 32'h007C_3E00, "R1 dmcr literal");
    chk({31'h0, irq}, 0, "R1 irq");

    wr(8'h04, 32'h5A3); wr(8'h30, 32'h3A_0745); wr(8'h10, 32'h12);
    wr(8'h2C, 32'h8B); wr(8'h08, 32'h7); wr(8'h00, 32'h2);
    chk({clk_div, 5'h0, sda_delay}, {8'hA3, 5'h0, 3'h5}, "R12 ccr fields");
    chk({eng_rt_addr, eng_hw_addr}, 24'h3A0745, "R12 dar fields");

    // R2 launch, R5 blocked write, R3/R4 byte read
    wr(8'h00, 32'h82); rd(8'h00, "R2 busy readback");
    chk(bus_rdata, 32'h82, "R2 busy literal");
    wr(8'h1C, 32'h1234); rd(8'h1C, "R5 data ignored");
    chk(bus_rdata, 0, "R5 data literal");
    idle(2); finish_xfer(0, 0, 0, 32'hDEAD_BEEF);
    rd(8'h1C, "R4 byte read"); chk(bus_rdata, 32'hEF, "R4 byte literal");
    rd(8'h0C, "R3 over+loadbusy"); chk(bus_rdata, 32'h5, "R3 ints literal");
    chk({31'h0, irq}, 1, "R7 irq high");
    wr(8'h0C, 32'h1); rd(8'h0C, "R6 w1c bit0"); chk(bus_rdata, 32'h4, "R6 literal");
    wr(8'h0C, 32'h0); rd(8'h0C, "R6 write zero keeps");
    wr(8'h0C, 32'h4); rd(8'h0C, "R6 w1c bit2");

    // R3 error detail with half-word read
    wr(8'h2C, 32'h9C); wr(8'h00, 32'h82); idle(1);
    finish_xfer(1, 1, 4'h9, 32'hCAFE_F00D);
    rd(8'h0C, "R3 error detail"); chk(bus_rdata, 32'h0001_0903, "R3 detail literal");
    rd(8'h1C, "R4 half read"); chk(bus_rdata, 32'hF00D, "R4 half literal");
    wr(8'h0C, 32'h7);

    // R8 abort, late done ignored, idle abort ignored
    wr(8'h2C, 32'hA6); wr(8'h00, 32'h82); wr(8'h00, 32'h42);
    rd(8'h00, "R8 abort clears busy"); chk(bus_rdata, 32'h2, "R8 ctrl literal");
    rd(8'h0C, "R8 error flag");
    finish_xfer(0, 0, 0, 32'h7777_7777);
    rd(8'h0C, "R8 late done ignored"); rd(8'h1C, "R8 data untouched");
    wr(8'h0C, 32'h7); wr(8'h00, 32'h42); rd(8'h0C, "R8 idle abort no effect");

    // R4 write command leaves DATA, then full-word read
    wr(8'h2C, 32'h4E); wr(8'h1C, 32'h55AA); wr(8'h00, 32'h82);
    finish_xfer(0, 0, 0, 32'h1111_1111);
    rd(8'h1C, "R4 write cmd keeps data"); chk(bus_rdata, 32'h55AA, "R4 keep literal");
    wr(8'h00, 32'h0); chk({31'h0, irq}, 0, "R7 gie off");
    wr(8'h2C, 32'hA6); wr(8'h00, 32'h82); finish_xfer(0, 0, 0, 32'h89AB_CDEF);
    rd(8'h1C, "R4 word read");

    // R11 line control
    wr(8'h24, 32'hA); sda_in = 1; scl_in = 0; rd(8'h24, "R11 sda live");
    chk(bus_rdata, 32'h1A, "R11 literal");
    scl_in = 1; rd(8'h24, "R11 scl live");

    // R10 init request, launch refused while pending
    wr(8'h28, 32'h8011_2233); rd(8'h28, "R10 init pending");
    chk(bus_rdata, 32'h8011_2233, "R10 literal");
    wr(8'h00, 32'h80); rd(8'h00, "R10 launch refused");
    @(negedge clk); #1 init_done = 1; @(negedge clk); #1 init_done = 0;
    rd(8'h28, "R10 init cleared");

    // R9 soft reset
    wr(8'h0C, 32'h0); wr(8'h00, 32'h3);
    rd_now(8'h00, "R9 srst visible"); chk(bus_rdata, 32'h1, "R9 srst literal");
    foreach (u_rst_list[i]) rd(u_rst_list[i], "R9 back to reset");
    rd(8'h28, "R9 dmcr default"); chk(bus_rdata, 32'h007C_3E00, "R9 dmcr literal");
    idle(2);
    summary();
  end

  bit [7:0] u_rst_list [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h1C,
                                8'h24, 8'h2C, 8'h30, 8'h28};
endmodule